// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a processor-style interval timer. A 32-bit up-counter advances by one on every cycle in which the tick-enable input is high. A 32-bit compare register holds a target value. When the counter steps onto the target, a latched timer interrupt is raised. It stays raised until software writes the compare register again. The count rate is set entirely by how often the tick-enable input is pulsed, and a freeze input stops counting without losing the current value.

Software reaches both registers through a one-word write port and a combinational read port, each with a one-bit register address. The latched interrupt is routed to one of eight interrupt lines, chosen by a 3-bit select input. A pending status bit mirrors the interrupt, but only while a feature-enable input is high. Otherwise the line is still driven and the status bit is left alone.

Top module: `cc_timer`

## Requirements
- R1: When `tick_en` is high, `cnt_freeze` is low and no counter write happens, the counter increases by one at the clock edge, wrapping from 0xFFFFFFFF to 0. When `tick_en` is low, the counter holds its value.
- R2: While `rst_n` is low at a clock edge, the counter becomes 1, the compare register becomes 0, and both the interrupt and `irq_pend` become 0.
- R3: While `cnt_freeze` is high, the counter holds its value and no new interrupt is raised. An interrupt that is already raised stays raised.
- R4: A write with `wr_addr` = 0 loads `wr_data` into the counter at that edge. This happens whether or not `cnt_freeze` is high, and the load takes priority over a tick in the same cycle.
- R5: When the counter advances by a tick to a value equal to the compare register, the interrupt is raised at that same edge and held on later cycles. A counter value that equals the compare register through a write to either register does not raise it.
- R6: A write with `wr_addr` = 1 loads `wr_data` into the compare register and lowers the interrupt at that edge. This holds even when the value written is unchanged, and the write takes priority over a match in the same cycle.
- R7: `irq_pend` is set together with the interrupt and cleared by a compare write only while `r2_feat` is high in that cycle. While `r2_feat` is low, `irq_pend` keeps its value.
- R8: `irq_out` is zero while the interrupt is low. While it is high, only bit `irq_sel` is set, and that bit follows `irq_sel` in the same cycle.
- R9: `rd_data` shows the counter when `rd_addr` = 0 and the compare register when `rd_addr` = 1, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse, one increment per high cycle |
| cnt_freeze | input | 1 | Holds the counter and blocks new interrupts |
| r2_feat | input | 1 | Enables updates of the pending status bit |
| irq_sel | input | 3 | Index of the interrupt line to drive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 counter, 1 compare |
| wr_data | input | 32 | Write value |
| rd_addr | input | 1 | Read target: 0 counter, 1 compare |
| rd_data | output | 32 | Read value |
| irq_pend | output | 1 | Timer-pending status bit |
| irq_out | output | 8 | Interrupt lines, at most one set |

## Verification
The hardest situation to reach is the counter wrapping past 0xFFFFFFFF onto a compare value of 0. Ticking up to it would take billions of cycles. The stimulus instead loads the counter with 0xFFFFFFFE through the write port, with the tick already running, and the write wins that cycle. The wrap and the match then follow within two ticks. Same-cycle collisions are also placed deliberately: a counter write against a tick, a compare write against a pending match, and a compare write of an equal value while frozen. A behavioural model is compared against the outputs on every clock.

// File: rtl/cctmr_pkg.sv
// Package: shared register-address encoding for the interval timer.
// Assumes a one-bit address selects between the two software registers.
package cctmr_pkg;
    typedef enum logic {
        REG_COUNT   = 1'b0,
        REG_COMPARE = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/cctmr_counter.sv
// Module: free-running counter with load.
// A load takes priority over a tick. Ticks are ignored while frozen.
// Assumes tick_en is a single-cycle-qualified enable in the clk domain.
module cctmr_counter #(
    parameter int unsigned CNT_W   = 32,
    parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_inc,
    output logic             advance
);
    // Qualify a tick: counting runs, and no software load this cycle.
    always_comb begin
        advance   = tick_en && !freeze && !load;
        count_inc = count_q + CNT_W'(1);
    end

    // Counter register: reset value, software load, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RST_VAL;
        end else if (load) begin
            count_q <= load_val;
        end else if (advance) begin
            count_q <= count_inc;
        end
    end
endmodule

// File: rtl/cctmr_match.sv
// Module: compare register, latched interrupt and pending status bit.
// A match is a counter step onto the compare value. A compare write
// clears the interrupt and wins over a match in the same cycle.
// The pending bit is only updated while feat_en is high.
module cctmr_match #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] count_inc,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             feat_en,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq_q,
    output logic             pend_q
);
    logic hit;

    // Detect the step of the counter onto the compare value.
    always_comb begin
        hit = advance && (count_inc == cmp_q) && !cmp_wr;
    end

    // Compare register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_val;
        end
    end

    // Latched interrupt: cleared by a compare write, set by a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (cmp_wr) begin
            irq_q <= 1'b0;
        end else if (hit) begin
            irq_q <= 1'b1;
        end
    end

    // Pending status bit, updated only while the feature is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (feat_en && cmp_wr) begin
            pend_q <= 1'b0;
        end else if (feat_en && hit) begin
            pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cctmr_route.sv
// Module: steers one interrupt onto one of LINES outputs.
// Purely combinational, so the output follows the select in the same
// cycle. Assumes sel is below LINES; an out-of-range index drives nothing.
module cctmr_route #(
    parameter int unsigned LINES = 8,
    localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             irq,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Drive line i when it is the selected one.
        always_comb begin
            lines[i] = irq && (sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/cc_timer.sv
// Module: Count/Compare interval timer top level.
// Decodes the register writes, muxes the read port, and connects the
// counter, the match logic and the line router. Assumes writes and
// reads are single-cycle and the software side is synchronous to clk.
module cc_timer #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LINES = 8,
    localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_freeze,
    input  logic             r2_feat,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_pend,
    output logic [LINES-1:0] irq_out
);
    import cctmr_pkg::*;

    logic             cnt_wr;
    logic             cmp_wr;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             advance;
    logic [CNT_W-1:0] cmp_q;
    logic             irq_q;

    // Split the write strobe by target register.
    always_comb begin
        cnt_wr = wr_en && (reg_addr_e'(wr_addr) == REG_COUNT);
        cmp_wr = wr_en && (reg_addr_e'(wr_addr) == REG_COMPARE);
    end

    cctmr_counter #(
        .CNT_W   (CNT_W),
        .RST_VAL (CNT_W'(1))
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .freeze    (cnt_freeze),
        .load      (cnt_wr),
        .load_val  (wr_data),
        .count_q   (count_q),
        .count_inc (count_inc),
        .advance   (advance)
    );

    cctmr_match #(
        .CNT_W (CNT_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .count_inc (count_inc),
        .cmp_wr    (cmp_wr),
        .cmp_val   (wr_data),
        .feat_en   (r2_feat),
        .cmp_q     (cmp_q),
        .irq_q     (irq_q),
        .pend_q    (irq_pend)
    );

    cctmr_route #(
        .LINES (LINES)
    ) u_route (
        .irq   (irq_q),
        .sel   (irq_sel),
        .lines (irq_out)
    );

    // Read port: combinational register select.
    always_comb begin
        rd_data = (reg_addr_e'(rd_addr) == REG_COMPARE) ? cmp_q : count_q;
    end
endmodule

// File: rtl/cc_timer_chk.sv
// Checker: temporal properties of the interval timer, bound to cc_timer.
module cc_timer_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LINES = 8,
    localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cnt_freeze,
    input logic             r2_feat,
    input logic [SEL_W-1:0] irq_sel,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq_pend,
    input logic [LINES-1:0] irq_out,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             irq_q
);
    AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_freeze && !wr_en) |=> (count_q == $past(count_q) + CNT_W'(1))); // R1
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_freeze && !wr_en) |=> $stable(count_q)); // R3
    AST_FREEZE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_freeze && !irq_q) |=> !irq_q); // R3
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (count_q == $past(wr_data))); // R4
    AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_freeze && !wr_en && (count_q + CNT_W'(1) == cmp_q)) |=> (irq_out != '0)); // R5
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (irq_out == '0 && cmp_q == $past(wr_data))); // R6
    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !r2_feat |=> (irq_pend == $past(irq_pend))); // R7
    AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out)); // R8
    AST_LINE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> irq_out[irq_sel]); // R8
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cnt_freeze (cnt_freeze),
    .r2_feat    (r2_feat),
    .irq_sel    (irq_sel),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .irq_pend   (irq_pend),
    .irq_out    (irq_out),
    .count_q    (count_q),
    .cmp_q      (cmp_q),
    .irq_q      (irq_q)
);

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cnt_freeze = 1'b0;
    logic        r2_feat = 1'b1;
    logic [2:0]  irq_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        irq_pend;
    logic [7:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R2";

    // Reference model state
    logic [31:0] m_cnt = 32'd1;
    logic [31:0] m_cmp = 32'd0;
    bit          m_irq = 1'b0;
    bit          m_pend = 1'b0;

    always #2 clk = ~clk;

    cc_timer i_cc_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_freeze(cnt_freeze),
        .r2_feat(r2_feat), .irq_sel(irq_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_pend(irq_pend), .irq_out(irq_out)
    );

    // Behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        bit ev;
        bit wc;
        bit wp;
        if (!rst_n) begin
            m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 0; m_pend = 0;
        end else begin
            wc = wr_en && !wr_addr;
            wp = wr_en && wr_addr;
            ev = tick_en && !cnt_freeze && !wc && !wp && (m_cnt + 32'd1 == m_cmp);
            if (wc) m_cnt = wr_data;
            else if (tick_en && !cnt_freeze) m_cnt = m_cnt + 32'd1;
            if (wp) begin
                m_cmp = wr_data; m_irq = 0;
                if (r2_feat) m_pend = 0;
            end else if (ev) begin
                m_irq = 1;
                if (r2_feat) m_pend = 1;
            end
        end
    end

    task automatic check_outputs();
        logic [31:0] e_rd;
        logic [7:0]  e_out;
        e_rd  = rd_addr ? m_cmp : m_cnt;
        e_out = m_irq ? (8'd1 << irq_sel) : 8'd0;
        checks++;
        if (rd_data !== e_rd) begin
            errors++;
            $display("FAIL %s rd_data act=%h exp=%h (R9 path)", cur_req, rd_data, e_rd);
        end
        checks++;
        if (irq_out !== e_out) begin
            errors++;
            $display("FAIL %s irq_out act=%b exp=%b", cur_req, irq_out, e_out);
        end
        checks++;
        if (irq_pend !== m_pend) begin
            errors++;
            $display("FAIL %s irq_pend act=%b exp=%b", cur_req, irq_pend, m_pend);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_outputs();
            rd_addr = ~rd_addr;
        end
    endtask

    task automatic wr(bit addr, logic [31:0] d);
        wr_en = 1; wr_addr = addr; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    initial begin
        // R2: reset values
        cur_req = "R2";
        step(3);
        rst_n = 1;
        step(2);

        // R1: counting with tick patterns
        cur_req = "R1";
        tick_en = 1; step(10);
        for (int k = 0; k < 12; k++) begin tick_en = k[0]; step(1); end
        tick_en = 0; step(3);

        // R5: match by tick raises and holds; pending set with feature on
        cur_req = "R5";
        wr(1, m_cnt + 32'd6);
        tick_en = 1; step(12);

        // R8: line follows the select in the same cycle
        cur_req = "R8";
        for (int s = 0; s < 8; s++) begin irq_sel = 3'(s); step(1); end

        // R6: compare write clears, also with the unchanged value
        cur_req = "R6";
        wr(1, m_cmp + 32'd3);
        step(5);
        wr(1, m_cmp);
        step(2);
        // compare write exactly in the matching cycle
        wr(1, m_cnt + 32'd3);
        step(1);
        wr(1, m_cnt + 32'd1);
        step(3);

        // R3: freeze holds the counter and blocks a new interrupt
        cur_req = "R3";
        wr(1, m_cnt + 32'd2);
        cnt_freeze = 1; step(8);
        wr(1, m_cnt);
        step(3);
        wr(1, m_cnt + 32'd1);
        step(3);

        // R4: counter write while frozen, then against a running tick
        cur_req = "R4";
        wr(0, 32'h1234_5678);
        step(2);
        cnt_freeze = 0;
        wr(0, 32'h0000_0100);
        step(3);

        // R7: feature off, pending untouched while the line still fires
        cur_req = "R7";
        wr(1, m_cnt + 32'd3);
        step(4);
        r2_feat = 0;
        wr(1, m_cnt + 32'd3);
        step(5);
        wr(1, m_cnt + 32'd2);
        step(4);
        r2_feat = 1;
        wr(1, m_cnt + 32'd50);
        step(2);

        // R1: wrap from the top onto a compare value of zero
        cur_req = "R1";
        wr(1, 32'h0000_0000);
        wr(0, 32'hFFFF_FFFE);
        step(5);

        // R9: both read targets once more, counter idle
        cur_req = "R9";
        tick_en = 0; step(4);

        // R2: reset in the middle of activity
        cur_req = "R2";
        tick_en = 1; rst_n = 0; step(2);
        rst_n = 1; tick_en = 0; step(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule